// File: doc/BRIEF.md
# Fan Cooling Failsafe and Bus Watchdog

This block stands between a serial-bus register decoder and two 8-bit fan current DACs. It holds the code that was last written for each channel, and it overrides both channels with the full-scale code whenever the system may have lost control of cooling. Three events trigger the override. The first is a high level on the failsafe pin when the block comes out of reset. The second is a high-to-low transition on that pin at any later time. The third is a long stretch with no bus traffic while the pin is held high.

After an override, each channel stays at full scale until the bus writes that channel again. The failsafe pin is asynchronous, so it passes through a synchronizer chain before the block looks at its level or its edges. The inactivity watchdog counts slow ticks that are divided down from the core clock. The defaults give 4,500,000 ticks at 50 kHz, which is 90 seconds. Every bus access restarts the count, and DAC writes count as accesses.

Top module: `fan_failsafe_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, both DAC outputs equal RESET_CODE (default 0).
- R2: If the synchronized pin is high at the start-up check, both outputs become full scale after the edge SYNC_STAGES+1 clocks after reset release.
- R3: If the pin is low at the start-up check, the outputs are not forced.
- R4: A high-to-low pin transition after start-up forces both outputs to full scale. The output changes on the edge SYNC_STAGES clocks after the first edge that samples the low level.
- R5: A low-to-high pin transition leaves both outputs unchanged.
- R6: A write strobe on a channel loads that channel's data on the next edge and clears its forced state. The other channel is untouched.
- R7: While the pin is high, a run of TICK_DIV*TIMEOUT_TICKS clocks with no access forces both outputs to full scale on the last edge of that run, and not earlier.
- R8: A bus access or any DAC write restarts the watchdog count.
- R9: While the synchronized pin is low, the watchdog never forces the outputs.
- R10: When a force and a write fall on the same edge, the force wins and the written data is dropped.
- R11: Full scale is the all-ones code (255 for 8 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| failsafe_pin | input | 1 | Asynchronous failsafe control pin |
| bus_access | input | 1 | One-cycle strobe for any access to this device |
| wr_a | input | 1 | Write strobe for channel A |
| wr_data_a | input | DAC_W | Code to load into channel A |
| wr_b | input | 1 | Write strobe for channel B |
| wr_data_b | input | DAC_W | Code to load into channel B |
| dac_a | output | DAC_W | Effective code for channel A |
| dac_b | output | DAC_W | Effective code for channel B |

## Verification
A corrupted synchronizer or start-up counter shows up within a few clocks of reset or of a pin change. It appears as a missing or misplaced jump to full scale, or as a spurious jump on a rising edge. A faulty watchdog count shows up as a force that arrives one tick early or late, or as a force while the pin is low. A channel whose forced state is stuck hides its next write on the very next edge. The bench compares both codes with a behavioural model on every clock, so any of these faults is reported in the cycle it first reaches the ports.

// File: rtl/fan_fs_pkg.sv
package fan_fs_pkg;
   // Reasons that can push both channels to full scale
   typedef struct packed {
      logic boot;   // pin high at start-up check
      logic drop;   // falling edge on the pin
      logic idle;   // watchdog expiry
   } fs_cause_t;

   function automatic logic fs_any(input fs_cause_t c);
      return c.boot | c.drop | c.idle;
   endfunction
endpackage

// File: rtl/fs_pin_watch.sv
module fs_pin_watch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_level,
   output logic armed,
   output logic boot_force,
   output logic drop_force
);
   localparam int CW = $clog2(SYNC_STAGES + 1);

   logic [SYNC_STAGES-1:0] chain_q;
   logic [CW-1:0]          settle_cnt_q;
   logic                   armed_q;
   logic                   prev_q;
   logic                   settled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_async};
   end

   assign pin_level = chain_q[SYNC_STAGES-1];
   assign settled   = (settle_cnt_q == CW'(SYNC_STAGES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_cnt_q <= '0;
         armed_q      <= 1'b0;
         prev_q       <= 1'b0;
      end else begin
         if (!settled) settle_cnt_q <= settle_cnt_q + 1'b1;
         if (settled && !armed_q) armed_q <= 1'b1;
         if (settled) prev_q <= pin_level;
      end
   end

   assign armed      = armed_q;
   assign boot_force = settled & ~armed_q & pin_level;
   assign drop_force = armed_q & prev_q & ~pin_level;
endmodule

// File: rtl/fs_idle_watchdog.sv
module fs_idle_watchdog #(
   parameter int TICK_DIV      = 5000,
   parameter int TIMEOUT_TICKS = 4_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic kick,
   output logic expire
);
   localparam int IW = $clog2(TIMEOUT_TICKS + 1);

   logic          tick;
   logic          restart;
   logic [IW-1:0] idle_q;

   assign restart = ~enable | kick;

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PW = $clog2(TICK_DIV);
         logic [PW-1:0] pre_q;
         assign tick = (pre_q == PW'(TICK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (restart) pre_q <= '0;
            else if (tick)    pre_q <= '0;
            else              pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   assign expire = ~restart & tick & (idle_q == IW'(TIMEOUT_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idle_q <= '0;
      else if (restart) idle_q <= '0;
      else if (expire)  idle_q <= '0;
      else if (tick)    idle_q <= idle_q + 1'b1;
   end
endmodule

// File: rtl/fs_dac_channel.sv
module fs_dac_channel #(
   parameter int DAC_W      = 8,
   parameter int RESET_CODE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             force_full,
   input  logic             wr_en,
   input  logic [DAC_W-1:0] wr_data,
   output logic [DAC_W-1:0] dac
);
   logic [DAC_W-1:0] code_q;
   logic             forced_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= DAC_W'(RESET_CODE);
         forced_q <= 1'b0;
      end else if (force_full) begin
         forced_q <= 1'b1;
      end else if (wr_en) begin
         code_q   <= wr_data;
         forced_q <= 1'b0;
      end
   end

   assign dac = forced_q ? {DAC_W{1'b1}} : code_q;
endmodule

// File: rtl/fan_failsafe_ctrl.sv
module fan_failsafe_ctrl
   import fan_fs_pkg::*;
#(
   parameter int DAC_W         = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int TICK_DIV      = 5000,
   parameter int TIMEOUT_TICKS = 4_500_000,
   parameter int RESET_CODE    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             failsafe_pin,
   input  logic             bus_access,
   input  logic             wr_a,
   input  logic [DAC_W-1:0] wr_data_a,
   input  logic             wr_b,
   input  logic [DAC_W-1:0] wr_data_b,
   output logic [DAC_W-1:0] dac_a,
   output logic [DAC_W-1:0] dac_b
);
   localparam int NCH = 2;

   generate
      if (DAC_W < 1)        begin : g_bad_w    $error("DAC_W must be at least 1");        end
      if (SYNC_STAGES < 2)  begin : g_bad_sync $error("SYNC_STAGES must be at least 2");  end
      if (TICK_DIV < 1)     begin : g_bad_div  $error("TICK_DIV must be at least 1");     end
      if (TIMEOUT_TICKS < 1) begin : g_bad_to  $error("TIMEOUT_TICKS must be at least 1"); end
      if (RESET_CODE < 0 || RESET_CODE >= (2 ** DAC_W))
                            begin : g_bad_rst  $error("RESET_CODE out of range");         end
   endgenerate

   logic      pin_level;
   logic      armed;
   logic      boot_force;
   logic      drop_force;
   logic      idle_expire;
   logic      force_any;
   fs_cause_t cause;

   fs_pin_watch #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_async  (failsafe_pin),
      .pin_level  (pin_level),
      .armed      (armed),
      .boot_force (boot_force),
      .drop_force (drop_force)
   );

   fs_idle_watchdog #(.TICK_DIV(TICK_DIV), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_wd (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (armed & pin_level),
      .kick   (bus_access | wr_a | wr_b),
      .expire (idle_expire)
   );

   assign cause     = '{boot: boot_force, drop: drop_force, idle: idle_expire};
   assign force_any = fs_any(cause);

   logic [NCH-1:0]            wr_vec;
   logic [NCH-1:0][DAC_W-1:0] data_vec;
   logic [NCH-1:0][DAC_W-1:0] dac_vec;

   assign wr_vec   = {wr_b, wr_a};
   assign data_vec = {wr_data_b, wr_data_a};

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         fs_dac_channel #(.DAC_W(DAC_W), .RESET_CODE(RESET_CODE)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .force_full (force_any),
            .wr_en      (wr_vec[ch]),
            .wr_data    (data_vec[ch]),
            .dac        (dac_vec[ch])
         );
      end
   endgenerate

   assign dac_a = dac_vec[0];
   assign dac_b = dac_vec[1];
endmodule

// File: rtl/fan_failsafe_ctrl_chk.sv
module fan_failsafe_ctrl_chk #(
   parameter int DAC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_a,
   input logic             wr_b,
   input logic [DAC_W-1:0] wr_data_a,
   input logic [DAC_W-1:0] wr_data_b,
   input logic [DAC_W-1:0] dac_a,
   input logic [DAC_W-1:0] dac_b,
   input logic             force_any,
   input logic             drop_force,
   input logic             pin_level,
   input logic             idle_expire
);
   AST_FORCE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      force_any |=> (dac_a == {DAC_W{1'b1}} && dac_b == {DAC_W{1'b1}})); // R11
   AST_DROP_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      drop_force |=> (dac_a == {DAC_W{1'b1}} && dac_b == {DAC_W{1'b1}})); // R4
   AST_WRITE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && !force_any) |=> (dac_a == $past(wr_data_a))); // R6
   AST_WRITE_B: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && !force_any) |=> (dac_b == $past(wr_data_b))); // R6
   AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_a && !force_any) |=> $stable(dac_a)); // R5
   AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_b && !force_any) |=> $stable(dac_b)); // R5
   AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_level |-> !idle_expire); // R9
endmodule

bind fan_failsafe_ctrl fan_failsafe_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_a        (wr_a),
   .wr_b        (wr_b),
   .wr_data_a   (wr_data_a),
   .wr_data_b   (wr_data_b),
   .dac_a       (dac_a),
   .dac_b       (dac_b),
   .force_any   (force_any),
   .drop_force  (drop_force),
   .pin_level   (pin_level),
   .idle_expire (idle_expire)
);

// File: tb/fan_failsafe_ctrl_tb.sv
`timescale 1ns/1ps
module fan_failsafe_ctrl_tb;
   localparam int W    = 8;
   localparam int SYNC = 2;
   localparam int DIV  = 4;
   localparam int TO   = 50;
   localparam int LIM  = DIV * TO;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         failsafe_pin = 1'b0;
   logic         bus_access = 1'b0;
   logic         wr_a = 1'b0;
   logic         wr_b = 1'b0;
   logic [W-1:0] wr_data_a = '0;
   logic [W-1:0] wr_data_b = '0;
   logic [W-1:0] dac_a;
   logic [W-1:0] dac_b;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   fan_failsafe_ctrl #(
      .DAC_W(W), .SYNC_STAGES(SYNC), .TICK_DIV(DIV), .TIMEOUT_TICKS(TO), .RESET_CODE(0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .failsafe_pin(failsafe_pin), .bus_access(bus_access),
      .wr_a(wr_a), .wr_data_a(wr_data_a), .wr_b(wr_b), .wr_data_b(wr_data_b),
      .dac_a(dac_a), .dac_b(dac_b)
   );

   // Behavioural reference model
   bit       m_pipe[$];
   int       m_edges;
   bit       m_prev;
   int       m_wd;
   bit       m_s, m_armed, m_force, m_kick;
   bit [W-1:0] exp_a, exp_b;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pipe = {};
         for (int i = 0; i < SYNC; i++) m_pipe.push_back(1'b0);
         m_edges = 0; m_prev = 0; m_wd = 0;
         exp_a = '0; exp_b = '0;
      end else begin
         m_s     = m_pipe[0];
         m_armed = (m_edges > SYNC);
         m_force = (m_edges == SYNC) && m_s;
         if (m_armed && m_prev && !m_s) m_force = 1'b1;
         m_kick = bus_access | wr_a | wr_b;
         if (!(m_armed && m_s) || m_kick) m_wd = 0;
         else if (m_wd == LIM - 1) begin m_force = 1'b1; m_wd = 0; end
         else m_wd++;
         if (m_force) begin
            exp_a = '1; exp_b = '1;
         end else begin
            if (wr_a) exp_a = wr_data_a;
            if (wr_b) exp_b = wr_data_b;
         end
         m_prev = m_s;
         m_pipe.push_back(failsafe_pin);
         void'(m_pipe.pop_front());
         if (m_edges <= SYNC) m_edges++;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (dac_a !== exp_a || dac_b !== exp_b) begin
            errors++;
            $display("FAIL %s model: dac_a=%h dac_b=%h expected %h %h at %0t",
                     cur_req, dac_a, dac_b, exp_a, exp_b, $time);
         end
      end
   end

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write(input bit a, input logic [W-1:0] da, input bit b, input logic [W-1:0] db);
      wr_a = a; wr_data_a = da; wr_b = b; wr_data_b = db;
      step(1);
      wr_a = 0; wr_b = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: bench did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 / R3: reset with pin low
      step(3);
      cur_req = "R1";
      check("R1 reset a", dac_a, 8'h00);
      check("R1 reset b", dac_b, 8'h00);
      rst_n = 1'b1;
      step(1);
      check("R1 after release", dac_a, 8'h00);
      cur_req = "R3";
      step(5);
      check("R3 no boot force a", dac_a, 8'h00);
      check("R3 no boot force b", dac_b, 8'h00);

      // R6: per-channel writes
      cur_req = "R6";
      write(1, 8'h40, 0, 8'h00);
      check("R6 write a", dac_a, 8'h40);
      check("R6 b untouched", dac_b, 8'h00);
      write(0, 8'h00, 1, 8'h9C);
      check("R6 write b", dac_b, 8'h9C);
      check("R6 a untouched", dac_a, 8'h40);

      // R5: rising edge has no effect
      cur_req = "R5";
      failsafe_pin = 1'b1;
      step(6);
      check("R5 rise a", dac_a, 8'h40);
      check("R5 rise b", dac_b, 8'h9C);

      // R8: accesses keep the watchdog from expiring
      cur_req = "R8";
      for (int k = 0; k < 3; k++) begin
         step(LIM - 20);
         bus_access = 1'b1; step(1); bus_access = 1'b0;
      end
      step(LIM - 20);
      write(0, 8'h00, 1, 8'h9D);
      step(LIM - 20);
      check("R8 kicked a", dac_a, 8'h40);
      check("R8 kicked b", dac_b, 8'h9D);

      // R7 / R11: expiry boundary
      cur_req = "R7";
      write(1, 8'h10, 0, 8'h00);
      check("R7 after write", dac_a, 8'h10);
      step(LIM - 1);
      check("R7 one before expiry", dac_a, 8'h10);
      step(1);
      check("R7 expiry a", dac_a, 8'hFF);
      check("R11 full scale b", dac_b, 8'hFF);

      // R4: falling edge
      cur_req = "R4";
      write(1, 8'h33, 1, 8'h44);
      check("R6 write clears force", dac_a, 8'h33);
      failsafe_pin = 1'b0;
      step(SYNC);
      check("R4 not yet", dac_a, 8'h33);
      step(1);
      check("R4 drop a", dac_a, 8'hFF);
      check("R4 drop b", dac_b, 8'hFF);

      // R9: no watchdog while pin low
      cur_req = "R9";
      write(1, 8'h55, 1, 8'h66);
      step(3 * LIM);
      check("R9 idle low a", dac_a, 8'h55);
      check("R9 idle low b", dac_b, 8'h66);

      // R10: force beats a write on the same edge
      cur_req = "R10";
      failsafe_pin = 1'b1;
      step(6);
      write(1, 8'h77, 1, 8'h78);
      failsafe_pin = 1'b0;
      step(SYNC);
      write(1, 8'h21, 0, 8'h00);
      check("R10 force wins", dac_a, 8'hFF);
      check("R10 other channel", dac_b, 8'hFF);

      // R2: start-up with pin high
      cur_req = "R2";
      rst_n = 1'b0;
      failsafe_pin = 1'b1;
      step(2);
      check("R1 reset again", dac_a, 8'h00);
      rst_n = 1'b1;
      step(SYNC);
      check("R2 before check", dac_a, 8'h00);
      step(1);
      check("R2 boot a", dac_a, 8'hFF);
      check("R2 boot b", dac_b, 8'hFF);
      step(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule